// File: doc/BRIEF.md
# Leaky-Integrator Neuron Layer Unit

This unit advances one layer of a retina-style neural model by one frame. Pixels arrive as a raster stream. Each pixel is mapped through a programmable 256-entry nonlinearity table. The unit then adds the layer's stored value for that pixel from the previous frame, scaled by a programmable decay factor. The sum saturates, can optionally be gated by a threshold, and leaves as the new output pixel. The same value is written back as the layer state. Spatial filtering is done by a separate pass outside this unit.

The layer state lives in an external frame memory. The surrounding logic presents the stored value of a pixel on `prev_state` in the same cycle as that pixel's input. It accepts a write-back of the new value on `wb_we`/`wb_data`, in the same raster order. All pixels of a layer share one decay factor and one table. Another layer is served by reloading them between frames.

Top module: `leaky_layer`

## Requirements
- R1: A table write (`lut_we` high) in a cycle where `in_valid` is low stores `lut_wdata` at entry `lut_addr`. Later pixels with that value use the new entry.
- R2: A table write in a cycle where `in_valid` is high is discarded, and the table entry keeps its old value.
- R3: The output pixel equals T[p] + floor((prev * alpha + 128) / 256). Here p is the input pixel, T is the table, prev is `prev_state`, and alpha is `cfg_alpha` read as an unsigned fraction of 256.
- R4: When that sum exceeds 255, the output is 255.
- R5: A frame begins at a valid pixel with `in_sof` high. Until the second frame start after reset, `prev_state` is ignored and taken as zero. From the second frame start on, including that pixel, it is used.
- R6: With `cfg_thr_en` high, an output whose saturated sum is below `cfg_thr_level` is 0. A sum equal to or above the level passes unchanged.
- R7: Each valid input pixel yields exactly one valid output two clock cycles later. Order, gaps and the start-of-frame flag are kept.
- R8: In every cycle `wb_we` equals `out_valid`, and when it is high `wb_data` equals `out_pixel`.
- R9: During and right after reset, `out_valid`, `out_sof`, `wb_we` and `out_pixel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_alpha | input | 8 | Decay factor, unsigned, value/256 |
| cfg_thr_en | input | 1 | Enables the threshold gate |
| cfg_thr_level | input | 8 | Threshold level |
| lut_we | input | 1 | Table write strobe |
| lut_addr | input | 8 | Table write entry |
| lut_wdata | input | 8 | Table write value |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame |
| in_pixel | input | 8 | Input pixel value |
| prev_state | input | 8 | Stored layer value for the current pixel |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output first pixel of a frame |
| out_pixel | output | 8 | Updated pixel value |
| wb_we | output | 1 | State memory write strobe |
| wb_data | output | 8 | State memory write value |

## Verification
A table load and pixel streaming can fall in the same cycle. The bench provokes this by pulsing a table write for a value that appears later in the same frame and in the next frame, while a pixel is valid. It judges the result by the outputs of those later pixels, which must still use the old entry. Afterwards the same write is repeated with no valid pixel, and the following frame must show the new entry. The first frame runs against a state memory preloaded with nonzero values, so any use of `prev_state` before the second frame start shows up in the output.

// File: rtl/lif_pkg.sv
package lif_pkg;
    parameter int unsigned PIX_W   = 8;
    parameter int unsigned ALPHA_W = 8;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        logic vld;
        logic sof;
        pix_t lutv;
        pix_t decayed;
        logic thr_en;
        pix_t thr;
    } s1_t;

    typedef struct packed {
        logic vld;
        logic sof;
        pix_t pix;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } pipe_t;
endpackage

// File: rtl/lif_table.sv
module lif_table #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          block,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we && !block) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

    AST_TABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !block) |=> mem_q[$past(waddr)] == $past(wdata)); // R1
    AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && block) |=> mem_q[$past(waddr)] == $past(mem_q[waddr])); // R2
endmodule

// File: rtl/lif_decay.sv
module lif_decay #(
    parameter int unsigned PW = 8,
    parameter int unsigned AW = 8
) (
    input  logic [PW-1:0] prev,
    input  logic [AW-1:0] alpha,
    input  logic          use_prev,
    output logic [PW-1:0] scaled
);
    localparam int unsigned PRW = PW + AW;
    localparam logic [PRW-1:0] HALF = PRW'(1) << (AW - 1);

    logic [PRW-1:0] prod;

    always_comb begin
        prod   = PRW'(prev) * PRW'(alpha) + HALF;
        scaled = use_prev ? PW'(prod >> AW) : '0;
    end
endmodule

// File: rtl/lif_frame_track.sv
module lif_frame_track (
    input  logic clk,
    input  logic rst_n,
    input  logic vld,
    input  logic sof,
    output logic first_px
);
    typedef struct packed {
        logic seen;
        logic first;
    } trk_t;

    trk_t d, q;

    always_comb begin
        d        = q;
        first_px = (vld && sof) ? !q.seen : q.first;
        if (vld && sof) begin
            d.seen  = 1'b1;
            d.first = !q.seen;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{seen: 1'b0, first: 1'b1};
        else        q <= d;
    end

    AST_SECOND_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && sof && q.seen) |=> !q.first); // R5
    AST_FIRST_UNTIL_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        !q.seen |-> q.first); // R5
endmodule

// File: rtl/leaky_layer.sv
module leaky_layer
    import lif_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ALPHA_W-1:0] cfg_alpha,
    input  logic               cfg_thr_en,
    input  logic [PIX_W-1:0]   cfg_thr_level,
    input  logic               lut_we,
    input  logic [PIX_W-1:0]   lut_addr,
    input  logic [PIX_W-1:0]   lut_wdata,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic [PIX_W-1:0]   in_pixel,
    input  logic [PIX_W-1:0]   prev_state,
    output logic               out_valid,
    output logic               out_sof,
    output logic [PIX_W-1:0]   out_pixel,
    output logic               wb_we,
    output logic [PIX_W-1:0]   wb_data
);
    localparam int unsigned SW = PIX_W + 1;

    pipe_t          d, q;
    pix_t           lut_rd;
    pix_t           scaled;
    logic           first_px;
    logic [SW-1:0]  sum;
    pix_t           sat;

    lif_table #(.AW(PIX_W), .DW(PIX_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (lut_we),
        .block (in_valid),
        .waddr (lut_addr),
        .wdata (lut_wdata),
        .raddr (in_pixel),
        .rdata (lut_rd)
    );

    lif_frame_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (in_valid),
        .sof      (in_sof),
        .first_px (first_px)
    );

    lif_decay #(.PW(PIX_W), .AW(ALPHA_W)) u_decay (
        .prev     (prev_state),
        .alpha    (cfg_alpha),
        .use_prev (!first_px),
        .scaled   (scaled)
    );

    always_comb begin
        d            = q;
        d.s1.vld     = in_valid;
        d.s1.sof     = in_valid && in_sof;
        d.s1.lutv    = lut_rd;
        d.s1.decayed = scaled;
        d.s1.thr_en  = cfg_thr_en;
        d.s1.thr     = cfg_thr_level;

        sum = {1'b0, q.s1.lutv} + {1'b0, q.s1.decayed};
        sat = sum[PIX_W] ? '1 : sum[PIX_W-1:0];

        d.s2.vld = q.s1.vld;
        d.s2.sof = q.s1.sof;
        if (!q.s1.vld)                         d.s2.pix = '0;
        else if (q.s1.thr_en && sat < q.s1.thr) d.s2.pix = '0;
        else                                    d.s2.pix = sat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.s2.vld;
    assign out_sof   = q.s2.sof;
    assign out_pixel = q.s2.pix;
    assign wb_we     = q.s2.vld;
    assign wb_data   = q.s2.pix;

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 2)); // R7
    AST_SOF_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid); // R7
    AST_SUM_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s1.vld && !q.s1.thr_en) |=> out_pixel >= $past(q.s1.lutv)); // R4
    AST_THR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s1.vld && q.s1.thr_en) |=> (out_pixel == '0 || out_pixel >= $past(q.s1.thr))); // R6
endmodule

// File: tb/leaky_layer_test.sv
module leaky_layer_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n;
    logic [7:0] cfg_alpha, cfg_thr_level, lut_addr, lut_wdata, in_pixel, prev_state;
    logic       cfg_thr_en, lut_we, in_valid, in_sof;
    logic       out_valid, out_sof, wb_we;
    logic [7:0] out_pixel, wb_data;

    leaky_layer uut (
        .clk(clk), .rst_n(rst_n), .cfg_alpha(cfg_alpha), .cfg_thr_en(cfg_thr_en),
        .cfg_thr_level(cfg_thr_level), .lut_we(lut_we), .lut_addr(lut_addr),
        .lut_wdata(lut_wdata), .in_valid(in_valid), .in_sof(in_sof),
        .in_pixel(in_pixel), .prev_state(prev_state), .out_valid(out_valid),
        .out_sof(out_sof), .out_pixel(out_pixel), .wb_we(wb_we), .wb_data(wb_data)
    );

    // external state memory model, written back in raster order
    logic [7:0] env_mem [16];
    int wr_ptr;
    always @(posedge clk) begin
        if (!rst_n) wr_ptr <= 0;
        else if (wb_we) begin
            env_mem[wr_ptr] <= wb_data;
            wr_ptr <= (wr_ptr + 1) % 16;
        end
    end

    int ref_lut [256];
    int ref_state [16];
    bit ref_first;
    int frames_sent;
    int q_pix [$];
    bit q_sof [$];
    string q_tag [$];
    string cur_tag;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pix_of(input int seed, input int i);
        if (seed == 0) return i * 16;
        return (seed * 37 + i * 53 + i * i * 7) & 255;
    endfunction

    // output monitor: R7 ordering/sof, R8 write-back
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (q_pix.size() == 0) check(1'b0, "R7", 1, 0);
                else begin
                    int e; bit s; string t;
                    e = q_pix.pop_front(); s = q_sof.pop_front(); t = q_tag.pop_front();
                    check(out_pixel == e[7:0], t, out_pixel, e);
                    check(out_sof == s, "R7", out_sof, s);
                    check(wb_we && wb_data == out_pixel, "R8", wb_data, out_pixel);
                end
            end else if (wb_we) check(1'b0, "R8", 1, 0);
        end
    end

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 0; in_sof = 0; lut_we = 0;
    endtask

    task automatic load_lut(input int kind);
        for (int i = 0; i < 256; i++) begin
            int v;
            @(negedge clk);
            in_valid = 0; in_sof = 0;
            v = (kind == 0) ? ((i * i) >> 8) : (128 + (i >> 1));
            lut_we = 1; lut_addr = i[7:0]; lut_wdata = v[7:0];
            ref_lut[i] = v;
        end
        idle_cycle();
    endtask

    task automatic send_frame(input int seed, input bit gaps, input int coll_at,
                              input int coll_addr, input int coll_data);
        if (frames_sent > 0) ref_first = 0;
        for (int i = 0; i < 16; i++) begin
            int p, lv, prev, sc, s, r;
            string t;
            if (gaps && (i % 3 == 1)) idle_cycle();
            p = pix_of(seed, i);
            lv = ref_lut[p];
            prev = ref_first ? 0 : ref_state[i];
            sc = (prev * cfg_alpha + 128) >> 8;
            s = lv + sc;
            if (s > 255) s = 255;
            r = (cfg_thr_en && s < cfg_thr_level) ? 0 : s;
            ref_state[i] = r;
            if (ref_first) t = "R5";
            else if (cfg_thr_en) t = "R6";
            else if (lv + sc > 255) t = "R4";
            else t = cur_tag;
            @(negedge clk);
            in_valid = 1; in_sof = (i == 0); in_pixel = p[7:0];
            prev_state = env_mem[i];
            lut_we = (i == coll_at);  // collision write: must be dropped (R2)
            lut_addr = coll_addr[7:0]; lut_wdata = coll_data[7:0];
            q_pix.push_back(r); q_sof.push_back(i == 0); q_tag.push_back(t);
        end
        idle_cycle();
        repeat (4) idle_cycle();
        check(q_pix.size() == 0, "R7", q_pix.size(), 0);
        frames_sent++;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int a, old;
        rst_n = 0; cfg_alpha = 8'hC0; cfg_thr_en = 0; cfg_thr_level = 0;
        lut_we = 0; lut_addr = 0; lut_wdata = 0;
        in_valid = 0; in_sof = 0; in_pixel = 0; prev_state = 0;
        ref_first = 1; frames_sent = 0; cur_tag = "R3";
        for (int i = 0; i < 16; i++) begin env_mem[i] = 8'hAA; ref_state[i] = 0; end
        repeat (3) @(negedge clk);
        // R9: outputs quiet during reset
        check(!out_valid && !out_sof && !wb_we && out_pixel == 0, "R9", out_pixel, 0);
        rst_n = 1;
        @(negedge clk);
        check(!out_valid && !out_sof && !wb_we && out_pixel == 0, "R9", out_pixel, 0);

        load_lut(0);
        // R5: first frame ignores nonzero stored state
        send_frame(1, 0, -1, 0, 0);
        // R3: decay from the second frame on, with gaps (R7)
        send_frame(2, 1, -1, 0, 0);
        send_frame(3, 0, -1, 0, 0);
        cfg_alpha = 8'h80;             // R3 rounding at half weight
        send_frame(4, 1, -1, 0, 0);

        // R2: table write while a pixel is valid is dropped
        a = pix_of(5, 9);
        old = ref_lut[a];
        cur_tag = "R2";
        send_frame(5, 0, 5, a, old ^ 8'h5A);
        send_frame(5, 0, -1, 0, 0);

        // R1: same write while idle takes effect
        @(negedge clk);
        lut_we = 1; lut_addr = a[7:0]; lut_wdata = 8'(old ^ 8'h5A);
        ref_lut[a] = old ^ 8'h5A;
        idle_cycle();
        cur_tag = "R1";
        send_frame(5, 0, -1, 0, 0);

        // R4: saturation with large table and full decay weight
        cur_tag = "R3";
        load_lut(1);
        cfg_alpha = 8'hFF;
        send_frame(6, 0, -1, 0, 0);
        send_frame(7, 1, -1, 0, 0);

        // R6: threshold gate, including the equal-to-level pixel (128 -> 192)
        cfg_alpha = 8'h00;
        cfg_thr_en = 1; cfg_thr_level = 8'd192;
        send_frame(0, 0, -1, 0, 0);
        cfg_alpha = 8'h40;
        send_frame(0, 1, -1, 0, 0);
        cfg_thr_en = 0;
        send_frame(8, 0, -1, 0, 0);

        finish_run();
    end
endmodule